// File: doc/BRIEF.md
# Power-Fail Store and Recall Controller

This controller sequences the copying of a byte-wide volatile memory into a nonvolatile shadow array, and the copying back. Two supply-monitor flags drive it. One says the supply is below the switch threshold and the other says it is below the reset threshold. It also takes a write-strobe pulse and software requests for a store or a recall. It drives a nonvolatile engine through four step commands: erase, program, clear and transfer. Each step lasts a fixed, parameterised number of clock cycles.

The controller tracks whether the volatile array is dirty. An automatic store on power loss therefore runs only when there is something new to save. A deep supply loss latches a recall request, and that recall runs once the supply is healthy again. While a cycle runs, the controller locks out all array access. While the supply is low, it inhibits writes and software stores.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: When `below_switch` rises, the controller is idle and the dirty flag is set, a store starts. `cmd_erase` goes high in the next cycle.
- R2: When `below_switch` rises and the dirty flag is clear, no store starts.
- R3: A one-cycle `sw_store_req` while idle with `below_switch` low starts a store, whether or not the array is dirty.
- R4: While `below_reset` is high, a recall request is latched. The controller must be idle with `below_switch` low for the recall to start: it runs `cmd_clear` for CLEAR_CYC cycles, then `cmd_xfer` for PU_XFER_CYC cycles.
- R5: A store asserts `cmd_erase` for exactly ERASE_CYC cycles and then `cmd_program` for exactly PROG_CYC cycles. At most one step command is high at any time.
- R6: A `sw_recall_req` while idle starts a recall, whatever the supply flags show. The recall asserts `cmd_clear` for CLEAR_CYC cycles and then `cmd_xfer` for XFER_CYC cycles.
- R7: `busy` and `access_off` stay high for every cycle of a store or recall. `wr_inhibit` is high throughout as well. A write strobe during that time does not set the dirty flag.
- R8: While `below_switch` is high, `wr_inhibit` is high, and both write strobes and `sw_store_req` are ignored.
- R9: A dip that sets `below_switch` but never `below_reset` causes no recall when the supply returns.
- R10: When store and recall requests arrive in the same idle cycle, the store runs. Requests that arrive while busy are dropped.
- R11: An accepted write sets the dirty flag. The dirty flag clears when a store or recall finishes.
- R12: After reset the controller is idle with all step commands low, the recall request pending and the dirty flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| below_switch | input | 1 | Supply is under the switch threshold |
| below_reset | input | 1 | Supply is under the reset threshold |
| wr_strobe | input | 1 | One-cycle pulse per array write |
| sw_store_req | input | 1 | Software store request |
| sw_recall_req | input | 1 | Software recall request |
| busy | output | 1 | A store or recall is running |
| access_off | output | 1 | Chip disable / IO lockout |
| wr_inhibit | output | 1 | Array writes blocked |
| cmd_erase | output | 1 | Erase nonvolatile contents |
| cmd_program | output | 1 | Program nonvolatile from volatile |
| cmd_clear | output | 1 | Clear volatile array |
| cmd_xfer | output | 1 | Transfer nonvolatile into volatile |

## Verification
The bench builds the controller with step lengths of 4, 5, 2, 3 and 6 cycles, in place of values in the millions. This makes every full store, software recall and power-up recall complete in a few dozen cycles. Each step length also differs from the others, so a step that is one cycle too long, or a power-up recall that uses the wrong transfer length, shows up at once. With such short cycles, the bench can chain dirty and clean brownouts, deep supply loss, requests that collide in one cycle and requests that arrive while busy, all in one run.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
package nvs_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_ERASE, ST_PROG, ST_CLEAR, ST_XFER} step_e;
  typedef enum logic [1:0] {OP_NONE, OP_STORE, OP_SW_RCL, OP_PU_RCL} op_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned max_len);
    return (max_len < 3) ? 1 : $clog2(max_len);
  endfunction
endpackage

// File: rtl/nvs_flag.sv
`timescale 1ns/1ps
module nvs_flag #(
  parameter bit RESET_VAL = 1'b0,
  parameter bit SET_WINS  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         flag_o <= RESET_VAL;
    else if (SET_WINS && set_i)         flag_o <= 1'b1;
    else if (clr_i)                     flag_o <= 1'b0;
    else if (set_i)                     flag_o <= 1'b1;
  end
endmodule

// File: rtl/nvs_arbiter.sv
`timescale 1ns/1ps
module nvs_arbiter
  import nvs_pkg::*;
(
  input  logic idle_i,
  input  logic low_i,
  input  logic fall_evt_i,
  input  logic dirty_i,
  input  logic pend_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  output op_e  op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (idle_i) begin
      if (fall_evt_i && dirty_i)        op_o = OP_STORE;
      else if (sw_store_i && !low_i)    op_o = OP_STORE;
      else if (pend_i && !low_i)        op_o = OP_PU_RCL;
      else if (sw_recall_i)             op_o = OP_SW_RCL;
    end
  end
endmodule

// File: rtl/nvs_sequencer.sv
`timescale 1ns/1ps
module nvs_sequencer
  import nvs_pkg::*;
#(
  parameter int unsigned ERASE_CYC   = 4,
  parameter int unsigned PROG_CYC    = 4,
  parameter int unsigned CLEAR_CYC   = 4,
  parameter int unsigned XFER_CYC    = 4,
  parameter int unsigned PU_XFER_CYC = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  op_e   op_i,
  output step_e step_o,
  output logic  done_o
);
  localparam int unsigned MAX_LEN =
    max2(max2(ERASE_CYC, PROG_CYC), max2(CLEAR_CYC, max2(XFER_CYC, PU_XFER_CYC)));
  localparam int unsigned CW = cnt_bits(MAX_LEN);

  logic [CW-1:0] cnt_q;
  logic          pu_q;

  function automatic logic [CW-1:0] len_m1(input step_e s, input logic pu);
    case (s)
      ST_ERASE: return CW'(ERASE_CYC - 1);
      ST_PROG:  return CW'(PROG_CYC - 1);
      ST_CLEAR: return CW'(CLEAR_CYC - 1);
      ST_XFER:  return pu ? CW'(PU_XFER_CYC - 1) : CW'(XFER_CYC - 1);
      default:  return '0;
    endcase
  endfunction

  assign done_o = (step_o == ST_PROG || step_o == ST_XFER) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_o <= ST_IDLE;
      cnt_q  <= '0;
      pu_q   <= 1'b0;
    end else if (step_o == ST_IDLE) begin
      if (op_i == OP_STORE) begin
        step_o <= ST_ERASE;
        cnt_q  <= len_m1(ST_ERASE, 1'b0);
      end else if (op_i != OP_NONE) begin
        step_o <= ST_CLEAR;
        cnt_q  <= len_m1(ST_CLEAR, 1'b0);
        pu_q   <= (op_i == OP_PU_RCL);
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      case (step_o)
        ST_ERASE: begin step_o <= ST_PROG; cnt_q <= len_m1(ST_PROG, pu_q); end
        ST_CLEAR: begin step_o <= ST_XFER; cnt_q <= len_m1(ST_XFER, pu_q); end
        default:  step_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nv_shadow_ctrl.sv
`timescale 1ns/1ps
module nv_shadow_ctrl
  import nvs_pkg::*;
#(
  parameter int unsigned ERASE_CYC   = 1250000,
  parameter int unsigned PROG_CYC    = 1250000,
  parameter int unsigned CLEAR_CYC   = 1000,
  parameter int unsigned XFER_CYC    = 4000,
  parameter int unsigned PU_XFER_CYC = 136500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_switch,
  input  logic below_reset,
  input  logic wr_strobe,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  output logic busy,
  output logic access_off,
  output logic wr_inhibit,
  output logic cmd_erase,
  output logic cmd_program,
  output logic cmd_clear,
  output logic cmd_xfer
);
  step_e step;
  op_e   op;
  logic  seq_done, dirty, recall_pend, low_q, fall_evt, wr_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b1;
    else        low_q <= below_switch;
  end

  assign fall_evt  = below_switch && !low_q;
  assign busy      = (step != ST_IDLE);
  assign access_off = busy;
  assign wr_inhibit = busy || below_switch;
  assign wr_accept = wr_strobe && !wr_inhibit;

  assign cmd_erase   = (step == ST_ERASE);
  assign cmd_program = (step == ST_PROG);
  assign cmd_clear   = (step == ST_CLEAR);
  assign cmd_xfer    = (step == ST_XFER);

  nvs_flag #(.RESET_VAL(1'b0), .SET_WINS(1'b0)) u_dirty (
    .clk(clk), .rst_n(rst_n), .set_i(wr_accept), .clr_i(seq_done), .flag_o(dirty));

  nvs_flag #(.RESET_VAL(1'b1), .SET_WINS(1'b1)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(below_reset), .clr_i(op == OP_PU_RCL),
    .flag_o(recall_pend));

  nvs_arbiter u_arb (
    .idle_i(!busy), .low_i(below_switch), .fall_evt_i(fall_evt), .dirty_i(dirty),
    .pend_i(recall_pend), .sw_store_i(sw_store_req), .sw_recall_i(sw_recall_req),
    .op_o(op));

  nvs_sequencer #(
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .CLEAR_CYC(CLEAR_CYC),
    .XFER_CYC(XFER_CYC), .PU_XFER_CYC(PU_XFER_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .op_i(op), .step_o(step), .done_o(seq_done));
endmodule

// File: rtl/nvs_checker.sv
`timescale 1ns/1ps
module nvs_checker (
  input logic clk,
  input logic rst_n,
  input logic below_switch,
  input logic below_reset,
  input logic sw_store_req,
  input logic sw_recall_req,
  input logic busy,
  input logic cmd_erase,
  input logic cmd_program,
  input logic cmd_clear,
  input logic cmd_xfer,
  input logic seq_done,
  input logic dirty,
  input logic recall_pend,
  input logic wr_accept
);
  assert_cmd_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_erase, cmd_program, cmd_clear, cmd_xfer}));
  assert_erase_to_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_erase) |-> cmd_program);
  assert_clear_to_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_clear) |-> cmd_xfer);
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !seq_done |=> busy);
  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !busy);
  assert_low_clean_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    below_switch && !dirty && !busy && !sw_recall_req |=> !busy);
  assert_dirty_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> dirty);
  assert_dirty_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !dirty);
  assert_pend_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    below_reset |=> recall_pend);
  assert_store_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && sw_store_req && !below_switch |=> cmd_erase);
endmodule

bind nv_shadow_ctrl nvs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .below_switch(below_switch), .below_reset(below_reset),
  .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req), .busy(busy),
  .cmd_erase(cmd_erase), .cmd_program(cmd_program), .cmd_clear(cmd_clear),
  .cmd_xfer(cmd_xfer), .seq_done(seq_done), .dirty(dirty),
  .recall_pend(recall_pend), .wr_accept(wr_accept));

// File: tb/sim_nv_shadow_ctrl.sv
`timescale 1ns/1ps
module sim_nv_shadow_ctrl;
  localparam int E = 4, P = 5, C = 2, X = 3, U = 6;
  localparam int K_ER = 1, K_PR = 2, K_CL = 3, K_XF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bsw = 1'b1, brst = 1'b1, wr = 1'b0, sst = 1'b0, srq = 1'b0;
  logic busy, access_off, wr_inhibit, cmd_erase, cmd_program, cmd_clear, cmd_xfer;
  int n_chk = 0, n_fail = 0;
  int c_er = 0, c_pr = 0, c_cl = 0, c_xf = 0, c_busy = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nv_shadow_ctrl #(.ERASE_CYC(E), .PROG_CYC(P), .CLEAR_CYC(C), .XFER_CYC(X),
                   .PU_XFER_CYC(U)) u0 (
    .clk(clk), .rst_n(rst_n), .below_switch(bsw), .below_reset(brst),
    .wr_strobe(wr), .sw_store_req(sst), .sw_recall_req(srq), .busy(busy),
    .access_off(access_off), .wr_inhibit(wr_inhibit), .cmd_erase(cmd_erase),
    .cmd_program(cmd_program), .cmd_clear(cmd_clear), .cmd_xfer(cmd_xfer));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: a queue holding one entry per remaining busy cycle
  int  q[$];
  bit  m_dirty = 0, m_pend = 1, m_prev = 1;

  task automatic push_n(input int code, input int n);
    for (int i = 0; i < n; i++) q.push_back(code);
  endtask

  always @(posedge clk) begin
    bit idle, acc, fin, take;
    if (!rst_n) begin
      q.delete(); m_dirty = 0; m_pend = 1; m_prev = 1;
    end else begin
      idle = (q.size() == 0);
      acc  = wr && idle && !bsw;
      fin  = 0; take = 0;
      if (idle) begin
        if (bsw && !m_prev && m_dirty) begin push_n(K_ER, E); push_n(K_PR, P); end
        else if (sst && !bsw)          begin push_n(K_ER, E); push_n(K_PR, P); end
        else if (m_pend && !bsw)       begin push_n(K_CL, C); push_n(K_XF, U); take = 1; end
        else if (srq)                  begin push_n(K_CL, C); push_n(K_XF, X); end
      end else begin
        void'(q.pop_front());
        fin = (q.size() == 0);
      end
      if (brst) m_pend = 1; else if (take) m_pend = 0;
      if (fin) m_dirty = 0; else if (acc) m_dirty = 1;
      m_prev = bsw;
    end
  end

  always @(negedge clk) begin
    int head;
    head = (q.size() != 0) ? q[0] : 0;
    chk("R7 busy",        busy,        q.size() != 0);
    chk("R7 access_off",  access_off,  q.size() != 0);
    chk("R8 wr_inhibit",  wr_inhibit,  (q.size() != 0) || bsw);
    chk("R5 cmd_erase",   cmd_erase,   head == K_ER);
    chk("R5 cmd_program", cmd_program, head == K_PR);
    chk("R6 cmd_clear",   cmd_clear,   head == K_CL);
    chk("R6 cmd_xfer",    cmd_xfer,    head == K_XF);
    c_er += cmd_erase; c_pr += cmd_program; c_cl += cmd_clear;
    c_xf += cmd_xfer;  c_busy += busy;
  end

  task automatic zero();
    @(negedge clk); #1;
    c_er = 0; c_pr = 0; c_cl = 0; c_xf = 0; c_busy = 0;
  endtask
  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic set_low(input logic v);
    @(negedge clk); #1; bsw = v;
  endtask
  task automatic pulse(input int which);
    @(negedge clk); #1;
    if (which == 0) wr = 1; else if (which == 1) sst = 1; else srq = 1;
    @(negedge clk); #1;
    wr = 0; sst = 0; srq = 0;
  endtask

  task automatic wrap_up();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      wrap_up();
    end
  end

  initial begin
    waitc(3);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset cmds", {cmd_erase, cmd_program, cmd_clear, cmd_xfer}, 0);
    rst_n = 1;
    waitc(2); brst = 0; waitc(3);
    chk("R12 pending recall waits for supply", busy, 0);
    // R4: latched power-up recall runs once supply is back
    zero(); set_low(0); waitc(20);
    chk("R4 clear cycles", c_cl, C);
    chk("R4 pu xfer cycles", c_xf, U);
    chk("R4 no store", c_er, 0);
    // R1 / R11: dirty brownout stores
    pulse(0); zero(); set_low(1); waitc(20);
    chk("R1 erase cycles", c_er, E);
    chk("R1 program cycles", c_pr, P);
    // R9: shallow dip does not recall
    zero(); set_low(0); waitc(20);
    chk("R9 no recall after brownout", c_busy, 0);
    // R2: clean brownout does nothing
    zero(); set_low(1); waitc(20);
    chk("R2 clean brownout idle", c_busy, 0);
    set_low(0); waitc(3);
    // R3: software store while clean
    zero(); pulse(1); waitc(20);
    chk("R3 sw store erase", c_er, E);
    chk("R3 sw store program", c_pr, P);
    // R8: writes and sw store ignored while low
    set_low(1); waitc(3);
    zero(); pulse(0); pulse(1); waitc(10);
    chk("R8 sw store ignored when low", c_busy, 0);
    set_low(0); waitc(3);
    zero(); set_low(1); waitc(20);
    chk("R8 blocked write left array clean", c_busy, 0);
    set_low(0); waitc(3);
    // R10: same-cycle collision and request while busy
    zero();
    @(negedge clk); #1; sst = 1; srq = 1;
    @(negedge clk); #1; sst = 0; srq = 0;
    waitc(2); pulse(2); waitc(25);
    chk("R10 store won", c_er, E);
    chk("R10 recall dropped", c_cl, 0);
    // R7: write during busy is ignored
    zero(); pulse(1); waitc(2); pulse(0); waitc(20);
    set_low(1); waitc(20);
    chk("R7 write during store ignored", c_er, E);
    set_low(0); waitc(3);
    // R6: software recall
    zero(); pulse(2); waitc(15);
    chk("R6 clear cycles", c_cl, C);
    chk("R6 xfer cycles", c_xf, X);
    // R11: recall completion clears dirty
    pulse(0); pulse(2); waitc(15);
    zero(); set_low(1); waitc(20);
    chk("R11 recall cleared dirty", c_er, 0);
    // R4: deep loss again
    brst = 1; waitc(5); brst = 0; waitc(3);
    zero(); set_low(0); waitc(20);
    chk("R4 second pu clear", c_cl, C);
    chk("R4 second pu xfer", c_xf, U);
    finished = 1;
    wrap_up();
  end
endmodule